// File: doc/BRIEF.md
# Dynamically Scheduled Reservation Station Array

This block is the out-of-order scheduling core that sits between an in-order instruction stream and two arithmetic units. One instruction per cycle may be offered at the issue port. When a waiting slot of the matching kind is empty, the instruction is accepted. Add and subtract go to three slots in front of an adder. Multiply and divide go to two slots in front of a multiply/divide unit. Each source operand is then either copied from the internal register file or replaced by the tag of the slot that will produce it. The destination register's producer entry is pointed at the new slot, so later readers wait for the newest writer. Write-after-read and write-after-write hazards therefore never stall issue.

Finished results leave on one shared result bus as a tag and a value. Every waiting slot compares the bus tag with its pending operand tags and captures the value on a match. The register whose producer entry carries that tag takes the value. A slot hands its operation to its unit once both operands are values and the unit is idle. The units run for a fixed number of cycles and accept one operation at a time. A register read port lets the surrounding logic observe register values and whether a write is still outstanding.

Top module: `tomasulo_rs`

## Requirements
- R1: After reset every slot is empty, the result bus is idle, no register has a pending writer, and register i holds the value i+1.
- R2: Opcode 0 is add, 1 is subtract, 2 is multiply and 3 is divide. An accepted instruction takes the lowest-numbered empty slot of its kind. Add/subtract slots carry tags 1 to 3, multiply/divide slots carry tags 4 and 5, and tag 0 means "value present".
- R3: `iss_ready` is low exactly when every slot of the offered opcode's kind is occupied. Nothing is accepted while it is low, whatever happens to the other kind.
- R4: A source whose register has no pending writer is read as a value. Otherwise it holds the producer's tag, and the value is captured from the result bus when that tag is broadcast. A broadcast in the issue cycle itself is taken directly.
- R5: Issue overwrites the destination register's producer entry with the new slot's tag. A result from an older writer of that register is then not written to it, so the register ends with the newest writer's value.
- R6: A slot starts execution only when both operands are values and its unit is idle. Each unit works on one operation at a time and takes the lowest-numbered ready slot.
- R7: With idle units and ready operands, the result appears on the bus 3 cycles after the issue cycle for add/subtract, 4 for multiply and 13 for divide.
- R8: Results are 16-bit: add, subtract and multiply keep the low 16 bits, divide gives the unsigned quotient, and dividing by zero gives 0xFFFF.
- R9: At most one result is broadcast per cycle. When both units have a result ready, the multiply/divide unit goes first and the adder keeps its result unchanged for the following cycle.
- R10: On a broadcast, the register whose producer entry equals the tag takes the value and becomes not pending, and the producing slot becomes empty on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered this cycle |
| iss_op | input | 2 | Opcode: 0 add, 1 subtract, 2 multiply, 3 divide |
| iss_rd | input | 3 | Destination register |
| iss_rs1 | input | 3 | First source register |
| iss_rs2 | input | 3 | Second source register |
| iss_ready | output | 1 | An empty slot of the offered opcode's kind exists |
| cdb_valid | output | 1 | A result is on the bus this cycle |
| cdb_tag | output | 3 | Tag of the slot whose result is on the bus (0 when idle) |
| cdb_value | output | 16 | Result value on the bus |
| rf_addr | input | 3 | Register read address |
| rf_value | output | 16 | Current value of the addressed register |
| rf_pending | output | 1 | The addressed register waits for an outstanding result |

## Verification
The two units can finish in the same cycle and compete for the single result bus. The bench provokes this by issuing a multiply and then an add one cycle later. Both finish four cycles after the multiply's issue, and the bench expects the multiply's tag in that cycle and the add's tag exactly one cycle later, each with its correct value. A second collision is between an issue and a broadcast aimed at the same register. A long divide followed by a short add to the same destination must leave the add's value in place after the divide's later broadcast.

// File: rtl/tomasulo_rs_pkg.sv
`timescale 1ns/1ps
package tomasulo_rs_pkg;

  parameter int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;

  // multiply and divide share one unit; bit 1 of the opcode selects it
  function automatic logic uses_muldiv(rs_op_e op);
    return op[1];
  endfunction

  function automatic logic [DATA_W-1:0] fu_calc(rs_op_e op,
                                                logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] prod;
    prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return prod[DATA_W-1:0];
      default: return (b == '0) ? {DATA_W{1'b1}} : a / b;
    endcase
  endfunction

endpackage

// File: rtl/rs_station.sv
`timescale 1ns/1ps
module rs_station
  import tomasulo_rs_pkg::*;
#(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  rs_op_e            alloc_op,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic [TAG_W-1:0]  alloc_qk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              dispatch,
  output logic              busy,
  output logic              ready,
  output rs_op_e            op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [TAG_W-1:0]  qj,
  output logic [TAG_W-1:0]  qk
);

  logic started;
  logic release_me;
  logic hit_j, hit_k;

  assign release_me = cdb_valid && (cdb_tag == TAG_W'(MY_TAG));
  assign hit_j      = cdb_valid && (qj != '0) && (cdb_tag == qj);
  assign hit_k      = cdb_valid && (qk != '0) && (cdb_tag == qk);
  assign ready      = busy && !started && (qj == '0) && (qk == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      started <= 1'b0;
      op      <= OP_ADD;
      vj      <= '0;
      vk      <= '0;
      qj      <= '0;
      qk      <= '0;
    end else if (alloc) begin
      busy    <= 1'b1;
      started <= 1'b0;
      op      <= alloc_op;
      vj      <= alloc_vj;
      vk      <= alloc_vk;
      qj      <= alloc_qj;
      qk      <= alloc_qk;
    end else if (release_me) begin
      busy    <= 1'b0;
      started <= 1'b0;
    end else begin
      if (dispatch) started <= 1'b1;
      if (busy && hit_j) begin
        vj <= cdb_value;
        qj <= '0;
      end
      if (busy && hit_k) begin
        vk <= cdb_value;
        qk <= '0;
      end
    end
  end

endmodule

// File: rtl/rs_funit.sv
`timescale 1ns/1ps
module rs_funit
  import tomasulo_rs_pkg::*;
#(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned LAT_A = 2,   // latency of every op except divide
  parameter int unsigned LAT_B = 2,   // latency of divide
  localparam int unsigned MAXL  = (LAT_A > LAT_B) ? LAT_A : LAT_B,
  localparam int unsigned CNT_W = $clog2(MAXL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rs_op_e            start_op,
  input  logic [DATA_W-1:0] start_a,
  input  logic [DATA_W-1:0] start_b,
  input  logic [TAG_W-1:0]  start_tag,
  input  logic              grant,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [TAG_W-1:0]  tag
);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign busy = running;
  assign done = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      result  <= '0;
      tag     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= (start_op == OP_DIV) ? CNT_W'(LAT_B - 1) : CNT_W'(LAT_A - 1);
      result  <= fu_calc(start_op, start_a, start_b);
      tag     <= start_tag;
    end else if (running) begin
      if (cnt != '0)  cnt     <= cnt - 1'b1;
      else if (grant) running <= 1'b0;
    end
  end

endmodule

// File: rtl/tomasulo_rs.sv
`timescale 1ns/1ps
module tomasulo_rs
  import tomasulo_rs_pkg::*;
#(
  parameter int unsigned NREG    = 8,
  parameter int unsigned N_ADD   = 3,
  parameter int unsigned N_MUL   = 2,
  parameter int unsigned LAT_ADD = 2,
  parameter int unsigned LAT_MUL = 3,
  parameter int unsigned LAT_DIV = 12,
  localparam int unsigned NST    = N_ADD + N_MUL,
  localparam int unsigned TAG_W  = $clog2(NST + 1),
  localparam int unsigned IDX_W  = $clog2(NST),
  localparam int unsigned RA_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [RA_W-1:0]   iss_rd,
  input  logic [RA_W-1:0]   iss_rs1,
  input  logic [RA_W-1:0]   iss_rs2,
  output logic              iss_ready,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_value,
  input  logic [RA_W-1:0]   rf_addr,
  output logic [DATA_W-1:0] rf_value,
  output logic              rf_pending
);

  typedef struct packed {
    logic [DATA_W-1:0] v;
    logic [TAG_W-1:0]  q;
  } opnd_t;

  // value from the register file, or the producer tag, or a same-cycle bus hit
  function automatic opnd_t read_src(logic [DATA_W-1:0] val, logic [TAG_W-1:0] q,
                                     logic bus_v, logic [TAG_W-1:0] bus_t,
                                     logic [DATA_W-1:0] bus_d);
    opnd_t o;
    o.v = val;
    o.q = q;
    if (q != '0) begin
      o.v = '0;
      if (bus_v && bus_t == q) begin
        o.v = bus_d;
        o.q = '0;
      end
    end
    return o;
  endfunction

  rs_op_e            iss_kind;
  logic [NST-1:0]    st_busy, st_rdy, disp, opnd_ok;
  rs_op_e            st_op [NST];
  logic [DATA_W-1:0] st_vj [NST];
  logic [DATA_W-1:0] st_vk [NST];
  logic [TAG_W-1:0]  st_qj [NST];
  logic [TAG_W-1:0]  st_qk [NST];
  logic [DATA_W-1:0] rf_val [NREG];
  logic [TAG_W-1:0]  rf_tag [NREG];

  logic              sel_found, iss_fire;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  opnd_t             src_j, src_k;

  logic              add_any, mul_any, add_start, mul_start;
  logic [IDX_W-1:0]  add_pick, mul_pick;
  logic [TAG_W-1:0]  add_stag, mul_stag, add_rtag, mul_rtag;
  logic              add_busy, mul_busy, add_done, mul_done, add_grant, mul_grant;
  logic [DATA_W-1:0] add_res, mul_res;

  // ---------------- issue ----------------
  assign iss_kind = rs_op_e'(iss_op);

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int i = int'(NST) - 1; i >= 0; i--) begin
      if (((i >= int'(N_ADD)) == uses_muldiv(iss_kind)) && !st_busy[i]) begin
        sel_found = 1'b1;
        sel_idx   = IDX_W'(i);
      end
    end
  end

  assign iss_ready = sel_found;
  assign iss_fire  = iss_valid && sel_found;
  assign sel_tag   = TAG_W'(sel_idx) + TAG_W'(1);
  assign src_j     = read_src(rf_val[iss_rs1], rf_tag[iss_rs1], cdb_valid, cdb_tag, cdb_value);
  assign src_k     = read_src(rf_val[iss_rs2], rf_tag[iss_rs2], cdb_valid, cdb_tag, cdb_value);

  // ---------------- stations ----------------
  for (genvar g = 0; g < int'(NST); g++) begin : g_st
    rs_station #(.TAG_W(TAG_W), .MY_TAG(g + 1)) u_st (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (iss_fire && (sel_idx == IDX_W'(g))),
      .alloc_op  (iss_kind),
      .alloc_vj  (src_j.v),
      .alloc_qj  (src_j.q),
      .alloc_vk  (src_k.v),
      .alloc_qk  (src_k.q),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .dispatch  (disp[g]),
      .busy      (st_busy[g]),
      .ready     (st_rdy[g]),
      .op        (st_op[g]),
      .vj        (st_vj[g]),
      .vk        (st_vk[g]),
      .qj        (st_qj[g]),
      .qk        (st_qk[g])
    );
    assign opnd_ok[g] = (st_qj[g] == '0) && (st_qk[g] == '0);
  end

  // ---------------- dispatch: lowest ready slot per idle unit ----------------
  always_comb begin
    add_any  = 1'b0;
    add_pick = '0;
    for (int i = int'(N_ADD) - 1; i >= 0; i--) begin
      if (st_rdy[i]) begin
        add_any  = 1'b1;
        add_pick = IDX_W'(i);
      end
    end
    mul_any  = 1'b0;
    mul_pick = '0;
    for (int i = int'(NST) - 1; i >= int'(N_ADD); i--) begin
      if (st_rdy[i]) begin
        mul_any  = 1'b1;
        mul_pick = IDX_W'(i);
      end
    end
  end

  assign add_start = add_any && !add_busy;
  assign mul_start = mul_any && !mul_busy;
  assign add_stag  = TAG_W'(add_pick) + TAG_W'(1);
  assign mul_stag  = TAG_W'(mul_pick) + TAG_W'(1);

  always_comb begin
    for (int i = 0; i < int'(NST); i++) begin
      if (i < int'(N_ADD)) disp[i] = add_start && (add_pick == IDX_W'(i));
      else                 disp[i] = mul_start && (mul_pick == IDX_W'(i));
    end
  end

  rs_funit #(.TAG_W(TAG_W), .LAT_A(LAT_ADD), .LAT_B(LAT_ADD)) u_add (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (add_start),
    .start_op  (st_op[add_pick]),
    .start_a   (st_vj[add_pick]),
    .start_b   (st_vk[add_pick]),
    .start_tag (add_stag),
    .grant     (add_grant),
    .busy      (add_busy),
    .done      (add_done),
    .result    (add_res),
    .tag       (add_rtag)
  );

  rs_funit #(.TAG_W(TAG_W), .LAT_A(LAT_MUL), .LAT_B(LAT_DIV)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (mul_start),
    .start_op  (st_op[mul_pick]),
    .start_a   (st_vj[mul_pick]),
    .start_b   (st_vk[mul_pick]),
    .start_tag (mul_stag),
    .grant     (mul_grant),
    .busy      (mul_busy),
    .done      (mul_done),
    .result    (mul_res),
    .tag       (mul_rtag)
  );

  // ---------------- result bus: multiply/divide wins a tie ----------------
  assign mul_grant = mul_done;
  assign add_grant = add_done && !mul_done;
  assign cdb_valid = add_done || mul_done;
  assign cdb_tag   = mul_done ? mul_rtag : (add_done ? add_rtag : '0);
  assign cdb_value = mul_done ? mul_res  : (add_done ? add_res  : '0);

  // ---------------- register file with producer tags ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(NREG); r++) begin
        rf_val[r] <= DATA_W'(r + 1);
        rf_tag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < int'(NREG); r++) begin
        if (cdb_valid && (rf_tag[r] != '0) && (rf_tag[r] == cdb_tag)) begin
          rf_val[r] <= cdb_value;
          rf_tag[r] <= '0;
        end
        if (iss_fire && (iss_rd == RA_W'(r))) rf_tag[r] <= sel_tag;
      end
    end
  end

  assign rf_value   = rf_val[rf_addr];
  assign rf_pending = (rf_tag[rf_addr] != '0);

endmodule

// File: rtl/tomasulo_rs_chk.sv
`timescale 1ns/1ps
module tomasulo_rs_chk #(
  parameter int unsigned NST   = 5,
  parameter int unsigned N_ADD = 3,
  parameter int unsigned TAG_W = 3,
  parameter int unsigned DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic             add_done,
  input logic             mul_done,
  input logic             add_grant,
  input logic [DW-1:0]    add_res,
  input logic [NST-1:0]   st_busy,
  input logic [NST-1:0]   disp,
  input logic [NST-1:0]   opnd_ok
);

  a_r9_muldiv_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (add_done && mul_done) |-> (cdb_valid && cdb_tag > TAG_W'(N_ADD)));

  a_r9_add_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (add_done && !add_grant) |=> (add_done && $stable(add_res)));

  a_r3_no_alloc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> ($countones(st_busy) <= $past($countones(st_busy))));

  a_r6_operands_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(disp & ~opnd_ok)));

  a_r10_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TAG_W'(NST)));

endmodule

bind tomasulo_rs tomasulo_rs_chk #(
  .NST(NST), .N_ADD(N_ADD), .TAG_W(TAG_W), .DW(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .cdb_valid (cdb_valid),
  .cdb_tag   (cdb_tag),
  .add_done  (add_done),
  .mul_done  (mul_done),
  .add_grant (add_grant),
  .add_res   (add_res),
  .st_busy   (st_busy),
  .disp      (disp),
  .opnd_ok   (opnd_ok)
);

// File: tb/tomasulo_rs_tb.sv
`timescale 1ns/1ps
module tomasulo_rs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = 2'd0;
  logic [2:0]  iss_rd = 3'd0, iss_rs1 = 3'd0, iss_rs2 = 3'd0, rf_addr = 3'd0;
  logic        iss_ready, cdb_valid, rf_pending;
  logic [2:0]  cdb_tag;
  logic [15:0] cdb_value, rf_value;

  always #2 clk = ~clk;

  tomasulo_rs u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_ready(iss_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .rf_addr(rf_addr), .rf_value(rf_value), .rf_pending(rf_pending)
  );

  // {op, rd, rs1, rs2}; expected results come from the sequential model
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 3'd1, 3'd2, 3'd3},
    {2'd1, 3'd0, 3'd1, 3'd7},
    {2'd2, 3'd2, 3'd1, 3'd7},
    {2'd3, 3'd3, 3'd2, 3'd4},
    {2'd1, 3'd5, 3'd4, 3'd4},
    {2'd3, 3'd6, 3'd2, 3'd5},
    {2'd2, 3'd7, 3'd0, 3'd0},
    {2'd0, 3'd4, 3'd4, 3'd3}
  };

  logic [15:0] mdl [8];
  int ncheck = 0, nfail = 0, cyc = 0, nlog = 0;
  int lg_tag [64];
  int lg_val [64];
  int lg_cyc [64];
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cdb_valid && nlog < 64) begin
      lg_tag[nlog] = int'(cdb_tag);
      lg_val[nlog] = int'(cdb_value);
      lg_cyc[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  function automatic logic [15:0] ref_calc(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    logic [31:0] p;
    p = {16'd0, a} * {16'd0, b};
    if (op == 2'd0) return a + b;
    if (op == 2'd1) return a - b;
    if (op == 2'd2) return p[15:0];
    if (b == 16'd0) return 16'hFFFF;
    return a / b;
  endfunction

  function automatic int ref_lat(logic [1:0] op);
    return (op == 2'd3) ? 12 : ((op == 2'd2) ? 3 : 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", ncheck - nfail, ncheck);
      $finish;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic do_issue(input logic [1:0] op, input logic [2:0] rd,
                          input logic [2:0] a, input logic [2:0] b,
                          output int acc, output logic [15:0] exp);
    iss_op = op; iss_rd = rd; iss_rs1 = a; iss_rs2 = b; iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    exp = ref_calc(op, mdl[a], mdl[b]);
    mdl[rd] = exp;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic wait_log(input int want);
    int t = 0;
    while (nlog < want && t < 100) begin
      @(negedge clk);
      #1;
      t++;
    end
  endtask

  task automatic chk_reg(input logic [2:0] r, input string req);
    rf_addr = r;
    #0.2;
    chk(rf_value == mdl[r], req, "register value", rf_value, mdl[r]);
    chk(rf_pending == 1'b0, req, "register not pending", rf_pending, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    ncheck++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int acc0, acc1, acc2;
    logic [15:0] e0, e1, e2;
    for (int r = 0; r < 8; r++) mdl[r] = 16'(r + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1;
    chk(cdb_valid == 1'b0, "R1", "bus idle", cdb_valid, 0);
    iss_op = 2'd0; #0.2;
    chk(iss_ready == 1'b1, "R1", "add slot free", iss_ready, 1);
    iss_op = 2'd3; #0.2;
    chk(iss_ready == 1'b1, "R1", "muldiv slot free", iss_ready, 1);
    for (int r = 0; r < 8; r++) chk_reg(3'(r), "R1");
    @(negedge clk);

    // vector table: one instruction at a time (R2 R7 R8 R10)
    for (int v = 0; v < 8; v++) begin
      nlog = 0;
      do_issue(VEC[v][10:9], VEC[v][8:6], VEC[v][5:3], VEC[v][2:0], acc0, e0);
      wait_log(1);
      chk(lg_tag[0] == (VEC[v][10] ? 4 : 1), "R2", "tag of lowest free slot", lg_tag[0],
          VEC[v][10] ? 4 : 1);
      chk(lg_val[0] == int'(e0), "R8", "result value", lg_val[0], e0);
      chk(lg_cyc[0] - acc0 == ref_lat(VEC[v][10:9]) + 1, "R7", "issue to broadcast",
          lg_cyc[0] - acc0, ref_lat(VEC[v][10:9]) + 1);
      @(negedge clk);
      #1;
      chk_reg(VEC[v][8:6], "R10");
      @(negedge clk);
    end

    // R4 true dependence through a tag
    nlog = 0;
    do_issue(2'd2, 3'd4, 3'd2, 3'd3, acc0, e0);
    do_issue(2'd0, 3'd5, 3'd4, 3'd1, acc1, e1);
    rf_addr = 3'd5; #0.2;
    chk(rf_pending == 1'b1, "R4", "consumer dest pending", rf_pending, 1);
    wait_log(2);
    chk(lg_tag[0] == 4 && lg_cyc[0] == acc0 + 4, "R4", "producer broadcast cycle",
        lg_cyc[0] - acc0, 4);
    chk(lg_tag[1] == 1 && lg_cyc[1] == acc0 + 7, "R4", "consumer broadcast cycle",
        lg_cyc[1] - acc0, 7);
    chk(lg_val[1] == int'(e1), "R4", "consumer used forwarded value", lg_val[1], e1);
    @(negedge clk); #1;
    chk_reg(3'd4, "R4");
    chk_reg(3'd5, "R4");
    @(negedge clk);

    // R5 output dependence: newer short write must survive older long write
    nlog = 0;
    do_issue(2'd3, 3'd6, 3'd7, 3'd1, acc0, e0);
    do_issue(2'd0, 3'd6, 3'd2, 3'd3, acc1, e1);
    wait_log(2);
    chk(lg_tag[0] == 1 && lg_cyc[0] == acc1 + 3, "R5", "younger add first", lg_tag[0], 1);
    chk(lg_tag[1] == 4 && lg_cyc[1] == acc0 + 13, "R5", "older divide later", lg_cyc[1] - acc0, 13);
    @(negedge clk); #1;
    chk_reg(3'd6, "R5");
    @(negedge clk);

    // R3 R6 structural stall and unpipelined divide unit
    nlog = 0;
    do_issue(2'd3, 3'd0, 3'd7, 3'd1, acc0, e0);
    do_issue(2'd3, 3'd1, 3'd6, 3'd2, acc1, e1);
    iss_op = 2'd2; #0.5;
    chk(iss_ready == 1'b0, "R3", "muldiv slots full", iss_ready, 0);
    iss_op = 2'd1; #0.5;
    chk(iss_ready == 1'b1, "R3", "add slot still free", iss_ready, 1);
    @(negedge clk);
    chk(nlog == 0 && cdb_valid == 1'b0, "R3", "nothing extra accepted", nlog, 0);
    do_issue(2'd2, 3'd2, 3'd3, 3'd4, acc2, e2);
    chk(acc2 == acc0 + 14, "R3", "stalled issue accepted after slot freed", acc2 - acc0, 14);
    wait_log(3);
    chk(lg_tag[0] == 4 && lg_cyc[0] == acc0 + 13, "R6", "first divide", lg_cyc[0] - acc0, 13);
    chk(lg_tag[1] == 5 && lg_cyc[1] == acc0 + 26, "R6", "second divide waits for unit",
        lg_cyc[1] - acc0, 26);
    chk(lg_tag[2] == 4 && lg_cyc[2] == acc0 + 30, "R6", "multiply after divide",
        lg_cyc[2] - acc0, 30);
    chk(lg_val[2] == int'(e2), "R8", "multiply value", lg_val[2], e2);
    @(negedge clk); #1;
    chk_reg(3'd0, "R10");
    chk_reg(3'd1, "R10");
    chk_reg(3'd2, "R10");
    @(negedge clk);

    // R9 both units finish together
    nlog = 0;
    do_issue(2'd2, 3'd1, 3'd2, 3'd3, acc0, e0);
    do_issue(2'd0, 3'd2, 3'd4, 3'd5, acc1, e1);
    wait_log(2);
    chk(lg_tag[0] == 4 && lg_cyc[0] == acc0 + 4, "R9", "multiply wins tie", lg_tag[0], 4);
    chk(lg_val[0] == int'(e0), "R9", "multiply value", lg_val[0], e0);
    chk(lg_tag[1] == 1 && lg_cyc[1] == acc0 + 5, "R9", "add one cycle later",
        lg_cyc[1] - acc0, 5);
    chk(lg_val[1] == int'(e1), "R9", "held add value", lg_val[1], e1);
    @(negedge clk); #1;
    chk_reg(3'd1, "R9");
    chk_reg(3'd2, "R9");

    summary();
  end

endmodule